// File: doc/BRIEF.md
# Hashed Page-Table Group Matcher

This block looks up one translation in a hashed page table. A request carries a virtual page number, already shifted right by 12 bits. It also carries a base page-size index, an actual page-size index, a 2-bit segment-size code, a flag for primary or secondary hash, a flag for the entry layout, and the index of the group to search. The block turns the request into a compare word for the first doubleword of an entry. It then reads the eight entries of the group in ascending slot order, one per cycle, through a read port that returns data one cycle after the read is issued.

An entry matches when four conditions hold:
- its valid bit is set;
- its secondary-hash bit equals the requested hash kind;
- its large-page bit agrees with the actual page size;
- its first doubleword, with the low seven flag bits ignored, equals the compare word.

In the newer layout the segment-size field is stored in the second doubleword. The block moves that field into the first doubleword before it compares. The block returns the first matching slot and that slot's raw second doubleword, or a miss. A reserved segment-size code returns an error result at once, without any memory reads.

Requests and results use valid/ready handshakes. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no search is running and no result is waiting. A result stays on the outputs with `res_valid` high until a cycle where `res_ready` is high, and every result field stays constant until then. The read port has no back-pressure: each cycle with `rd_en` high is one read, and the memory must present the addressed entry on `rd_dw0`/`rd_dw1` in the following cycle.

Top module: `hpte_group_matcher`

## Requirements
- R1: Page-size indices 0, 1, 2 and 3 mean 4 KB, 64 KB, 16 MB and 16 GB pages, whose page-offset widths `s` are 12, 16, 24 and 34 bits. The compare word is built in three steps:
  - take `req_vpn` with its low 11 bits dropped;
  - when the base size has `s` > 23, clear the low `s`-23 bits of that value;
  - shift the result left by 7 and OR the segment-size code into bits 63:62.
- R2: A match needs bits 63:7 of the normalized first doubleword to equal the compare word. Bits 6:3 (lock, bolted and spare) have no effect on the result.
- R3: An entry whose first-doubleword bit 0 (valid) is clear never matches.
- R4: An entry matches only if first-doubleword bit 1 (secondary hash) equals `req_secondary`.
- R5: An entry matches only if first-doubleword bit 2 (large page) is set exactly when the actual page-size index is nonzero.
- R6: Layout selection:
  - `req_new_layout`=1: bits 63:52 of the first doubleword are disregarded, and the segment-size field is taken from bits 59:58 of the second doubleword and compared at bits 63:62;
  - `req_new_layout`=0: the first doubleword is compared as stored, and the second doubleword plays no part in the match.
- R7: Reads go to address {group, slot}, with slots taken in ascending order from 0 at one read per cycle. The first matching slot is reported with `res_hit`=1, its slot index and its raw second doubleword. No read is issued while a result is waiting.
- R8: When none of the eight slots matches, the result has `res_hit`=0, `res_err`=0 and `res_slot`=0.
- R9: Segment-size codes 0 (256 MB) and 1 (1 TB) are legal. A request with code 2 or 3 produces `res_err`=1 and `res_hit`=0, with no memory read. A legal request produces `res_err`=0.
- R10: While a search is running or a result is waiting, `req_ready` is low. A result stays valid and unchanged until it is accepted. In the cycle after acceptance, `res_valid` is low and `req_ready` is high.
- R11: After reset, `req_ready`=1, `res_valid`=0 and `rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_vpn | input | 64 | Virtual page number, shifted right by 12 |
| req_base_psize | input | PSZ_W | Base page-size index |
| req_act_psize | input | PSZ_W | Actual page-size index |
| req_ssize | input | 2 | Segment-size code |
| req_secondary | input | 1 | Search for secondary-hash entries |
| req_new_layout | input | 1 | Entries use the newer layout |
| req_group | input | GRP_W | Group index to search |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | GRP_W+log2(SLOTS) | Read address {group, slot} |
| rd_dw0 | input | 64 | First doubleword, valid one cycle after the read |
| rd_dw1 | input | 64 | Second doubleword, valid one cycle after the read |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken when high together with `res_valid` |
| res_hit | output | 1 | A matching entry was found |
| res_err | output | 1 | Reserved segment-size code |
| res_slot | output | log2(SLOTS) | Index of the matching slot |
| res_dw1 | output | 64 | Second doubleword of the matching entry |

## Verification
The hardest cases to reach from the ports are entries that differ from a true match in only one field: the valid bit, the hash kind, the large bit, a single page-number bit, or the segment-size field. This is worst in the newer layout, where that last field sits in the other doubleword. The stimulus sweeps every combination of base size, actual size, legal segment size, layout and hash kind. In each trial it fills the group with one-field decoys around a true entry, and moves that entry through every slot position, including none at all. Lock, bolted and high-garbage bits vary on every entry, so a decision must never depend on them.

// File: rtl/hptm_pkg.sv
package hptm_pkg;

  localparam int DW_W        = 64;
  localparam int FLAG_W      = 7;   // low flag bits excluded from the compare
  localparam int VPN_PRE     = 12;  // the page number arrives pre-shifted by this
  localparam int AVA_DROP    = 23;  // virtual-address bits omitted from the compare field
  localparam int SSZ_POS     = 62;  // segment size in the normalized first doubleword
  localparam int NEW_SSZ_POS = 58;  // segment size in the newer second doubleword
  localparam int NEW_KEEP_W  = 52;  // first-doubleword bits kept by the newer layout
  localparam int B_VALID     = 0;
  localparam int B_SEC       = 1;
  localparam int B_LARGE     = 2;

  typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_DONE} scan_st_e;

  function automatic int unsigned psize_shift(input int unsigned idx);
    case (idx)
      0:       return 12;
      1:       return 16;
      2:       return 24;
      default: return 34;
    endcase
  endfunction

  function automatic logic [DW_W-1:0] ava_mask(input int unsigned idx);
    int unsigned s;
    s = psize_shift(idx);
    if (s > AVA_DROP) return (DW_W'(1) << (s - AVA_DROP)) - DW_W'(1);
    return '0;
  endfunction

  function automatic logic seg_reserved(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/hptm_cmpword.sv
module hptm_cmpword
  import hptm_pkg::*;
#(
  parameter int PSZ_W = 2
) (
  input  logic [DW_W-1:0]  vpn,
  input  logic [PSZ_W-1:0] base_psize,
  input  logic [PSZ_W-1:0] act_psize,
  input  logic [1:0]       ssize,
  output logic [DW_W-1:0]  cmp_word,
  output logic             want_large
);
  localparam int NSZ = 1 << PSZ_W;

  logic [DW_W-1:0] mask_tab [NSZ];
  for (genvar k = 0; k < NSZ; k++) begin : g_mask
    assign mask_tab[k] = ava_mask(k);
  end

  logic [DW_W-1:0] ava;
  logic [DW_W-1:0] ava_m;

  assign ava        = vpn >> (AVA_DROP - VPN_PRE);
  assign ava_m      = ava & ~mask_tab[base_psize];
  assign cmp_word   = (ava_m << FLAG_W) | {ssize, {(DW_W-2){1'b0}}};
  assign want_large = (act_psize != '0);
endmodule

// File: rtl/hptm_entry_match.sv
module hptm_entry_match
  import hptm_pkg::*;
(
  input  logic [DW_W-1:0] dw0,
  input  logic [1:0]      alt_ssize,
  input  logic            new_layout,
  input  logic [DW_W-1:0] cmp_word,
  input  logic            want_large,
  input  logic            want_sec,
  output logic            match
);
  localparam logic [DW_W-1:0] KEEP_MASK = (DW_W'(1) << NEW_KEEP_W) - DW_W'(1);
  localparam logic [DW_W-1:0] FLAG_MASK = (DW_W'(1) << FLAG_W) - DW_W'(1);

  logic [DW_W-1:0] norm;
  logic            avpn_eq;

  always_comb begin
    if (new_layout) norm = (dw0 & KEEP_MASK) | {alt_ssize, {(DW_W-2){1'b0}}};
    else            norm = dw0;
  end

  assign avpn_eq = (((norm ^ cmp_word) & ~FLAG_MASK) == '0);
  assign match   = norm[B_VALID] && (norm[B_SEC] == want_sec) &&
                   (norm[B_LARGE] == want_large) && avpn_eq;
endmodule

// File: rtl/hptm_scan_ctrl.sv
module hptm_scan_ctrl
  import hptm_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_reserved,
  input  logic              slot_match,
  input  logic [DW_W-1:0]   rd_dw1,
  output logic              idle,
  output logic              rd_en,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic              res_err,
  output logic [SLOT_W-1:0] res_slot,
  output logic [DW_W-1:0]   res_dw1
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  scan_st_e          state;
  logic [CNT_W-1:0]  issue_cnt;
  logic              chk_vld;
  logic [SLOT_W-1:0] chk_slot;

  assign idle      = (state == SC_IDLE);
  assign res_valid = (state == SC_DONE);
  assign rd_en     = (state == SC_SCAN) && (issue_cnt < CNT_W'(SLOTS));
  assign rd_slot   = issue_cnt[SLOT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SC_IDLE;
      issue_cnt <= '0;
      chk_vld   <= 1'b0;
      chk_slot  <= '0;
      res_hit   <= 1'b0;
      res_err   <= 1'b0;
      res_slot  <= '0;
      res_dw1   <= '0;
    end else begin
      case (state)
        SC_IDLE: begin
          if (start) begin
            res_hit   <= 1'b0;
            res_slot  <= '0;
            res_dw1   <= '0;
            issue_cnt <= '0;
            chk_vld   <= 1'b0;
            res_err   <= start_reserved;
            state     <= start_reserved ? SC_DONE : SC_SCAN;
          end
        end
        SC_SCAN: begin
          chk_vld  <= rd_en;
          chk_slot <= rd_slot;
          if (rd_en) issue_cnt <= issue_cnt + CNT_W'(1);
          if (chk_vld && slot_match) begin
            res_hit  <= 1'b1;
            res_slot <= chk_slot;
            res_dw1  <= rd_dw1;
            chk_vld  <= 1'b0;
            state    <= SC_DONE;
          end else if (chk_vld && (chk_slot == LAST)) begin
            chk_vld <= 1'b0;
            state   <= SC_DONE;
          end
        end
        SC_DONE: begin
          if (res_ready) state <= SC_IDLE;
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_err) &&
    $stable(res_slot) && $stable(res_dw1)); // R10
  AST_ERR_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> !res_hit); // R9
  AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_slot == SLOT_W'($past(rd_slot) + 1'b1)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !rd_en); // R7
endmodule

// File: rtl/hpte_group_matcher.sv
module hpte_group_matcher
  import hptm_pkg::*;
#(
  parameter  int GRP_W  = 8,
  parameter  int SLOTS  = 8,
  parameter  int PSZ_W  = 2,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = GRP_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DW_W-1:0]   req_vpn,
  input  logic [PSZ_W-1:0]  req_base_psize,
  input  logic [PSZ_W-1:0]  req_act_psize,
  input  logic [1:0]        req_ssize,
  input  logic              req_secondary,
  input  logic              req_new_layout,
  input  logic [GRP_W-1:0]  req_group,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DW_W-1:0]   rd_dw0,
  input  logic [DW_W-1:0]   rd_dw1,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic              res_err,
  output logic [SLOT_W-1:0] res_slot,
  output logic [DW_W-1:0]   res_dw1
);
  logic [DW_W-1:0]   vpn_q;
  logic [PSZ_W-1:0]  base_q, act_q;
  logic [1:0]        ssz_q;
  logic              sec_q, lay_q;
  logic [GRP_W-1:0]  grp_q;
  logic              idle, req_fire, slot_match, want_large;
  logic [DW_W-1:0]   cmp_word;
  logic [SLOT_W-1:0] rd_slot;

  assign req_ready = idle;
  assign req_fire  = req_valid && req_ready;
  assign rd_addr   = {grp_q, rd_slot};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      base_q <= '0;
      act_q  <= '0;
      ssz_q  <= '0;
      sec_q  <= 1'b0;
      lay_q  <= 1'b0;
      grp_q  <= '0;
    end else if (req_fire) begin
      vpn_q  <= req_vpn;
      base_q <= req_base_psize;
      act_q  <= req_act_psize;
      ssz_q  <= req_ssize;
      sec_q  <= req_secondary;
      lay_q  <= req_new_layout;
      grp_q  <= req_group;
    end
  end

  hptm_cmpword #(.PSZ_W(PSZ_W)) u_cmp (
    .vpn        (vpn_q),
    .base_psize (base_q),
    .act_psize  (act_q),
    .ssize      (ssz_q),
    .cmp_word   (cmp_word),
    .want_large (want_large)
  );

  hptm_entry_match u_match (
    .dw0        (rd_dw0),
    .alt_ssize  (rd_dw1[NEW_SSZ_POS +: 2]),
    .new_layout (lay_q),
    .cmp_word   (cmp_word),
    .want_large (want_large),
    .want_sec   (sec_q),
    .match      (slot_match)
  );

  hptm_scan_ctrl #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (req_fire),
    .start_reserved (seg_reserved(req_ssize)),
    .slot_match     (slot_match),
    .rd_dw1         (rd_dw1),
    .idle           (idle),
    .rd_en          (rd_en),
    .rd_slot        (rd_slot),
    .res_valid      (res_valid),
    .res_ready      (res_ready),
    .res_hit        (res_hit),
    .res_err        (res_err),
    .res_slot       (res_slot),
    .res_dw1        (res_dw1)
  );

  AST_INVALID_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_dw0[B_VALID] |-> !slot_match); // R3
  AST_SEC_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dw0[B_SEC] != sec_q) |-> !slot_match); // R4
  AST_LARGE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dw0[B_LARGE] != (act_q != '0)) |-> !slot_match); // R5
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready); // R10
  AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && seg_reserved(req_ssize) |=> !rd_en && res_valid && res_err); // R9
endmodule

// File: tb/hpte_group_matcher_test.sv
`timescale 1ns/1ps
module hpte_group_matcher_test;
  localparam int GRP_W = 2;
  localparam int ADDR_W = GRP_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_vpn = '0;
  logic [1:0] req_base_psize = '0, req_act_psize = '0, req_ssize = '0;
  logic req_secondary = 1'b0, req_new_layout = 1'b0;
  logic [GRP_W-1:0] req_group = '0;
  logic rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [63:0] rd_dw0 = '0, rd_dw1 = '0;
  logic res_valid, res_ready = 1'b0, res_hit, res_err;
  logic [2:0] res_slot;
  logic [63:0] res_dw1;

  logic [63:0] m0 [32];
  logic [63:0] m1 [32];
  int checks = 0, errors = 0;
  int rd_cnt = 0, order_err = 0, cur_grp = 0;
  logic cnt_clr = 1'b0;

  always #5 clk = ~clk;

  hpte_group_matcher #(.GRP_W(GRP_W)) uut (.*);

  always @(posedge clk) begin
    if (rd_en) begin
      rd_dw0 <= m0[rd_addr];
      rd_dw1 <= m1[rd_addr];
    end
    if (cnt_clr) rd_cnt <= 0;
    else if (rd_en) begin
      if (int'(rd_addr[2:0]) != rd_cnt || int'(rd_addr[ADDR_W-1:3]) != cur_grp)
        order_err <= order_err + 1;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_cmp(input logic [63:0] vpn, input int base, input int ssz);
    logic [63:0] q, m;
    int s;
    case (base)
      0: s = 12;
      1: s = 16;
      2: s = 24;
      default: s = 34;
    endcase
    q = vpn / 64'd2048;
    if (s > 23) begin
      m = 64'd1 << (s - 23);
      q = q - (q % m);
    end
    return q * 64'd128 + (64'(ssz) << 62);
  endfunction

  // fill group g; slot p holds the true entry (p==8: none), others are one-field decoys
  task automatic fill_group(input int g, input int p, input int t, input logic [63:0] cmp,
                            input logic sec, input logic lg, input logic [1:0] ssz, input logic lay);
    for (int j = 0; j < 8; j++) begin
      logic [63:0] d0, d1;
      d1 = 64'hC3A5_0F1E_5A69_0000 ^ (64'(t) << 16) ^ 64'(j * 4099);
      if (lay) begin
        d1[59:58] = ssz;
        d0 = (cmp & ((64'd1 << 52) - 1)) | (64'((t * 13 + j) % 4096) << 52);
      end else d0 = cmp;
      d0[0] = 1'b1;
      d0[1] = sec;
      d0[2] = lg;
      d0[6:3] = 4'((t + j) % 16);
      if (j != p) begin
        case ((j + t) % 5)
          0: d0[0] = 1'b0;
          1: d0[1] = ~sec;
          2: d0[2] = ~lg;
          3: d0[7 + ((t * 7 + j) % 45)] = ~d0[7 + ((t * 7 + j) % 45)];
          default: if (lay) d1[58] = ~d1[58]; else d0[62] = ~d0[62];
        endcase
      end
      m0[g * 8 + j] = d0;
      m1[g * 8 + j] = d1;
    end
  endtask

  task automatic run_search(input logic [63:0] vpn, input int base, input int act, input int ssz,
                            input logic sec, input logic lay, input int g,
                            input bit exp_hit, input bit exp_err, input int exp_slot,
                            input logic [63:0] exp_dw1, input int hold);
    int w, oe0;
    logic h0, e0;
    logic [2:0] s0;
    logic [63:0] d0;
    bit stable_ok;
    oe0 = order_err;
    cur_grp = g;
    req_vpn = vpn;
    req_base_psize = 2'(base);
    req_act_psize = 2'(act);
    req_ssize = 2'(ssz);
    req_secondary = sec;
    req_new_layout = lay;
    req_group = GRP_W'(g);
    req_valid = 1'b1;
    cnt_clr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt_clr = 1'b0;
    w = 0;
    while (!res_valid && w < 40) begin
      @(negedge clk);
      w++;
    end
    check(res_valid, "R7 search completes", 64'(res_valid), 64'd1);
    check(res_err == exp_err, "R9 error flag", 64'(res_err), 64'(exp_err));
    check(res_hit == exp_hit, "R1 R2 R3 R4 R5 R6 hit decision", 64'(res_hit), 64'(exp_hit));
    if (exp_hit) begin
      check(int'(res_slot) == exp_slot, "R7 first matching slot", 64'(res_slot), 64'(exp_slot));
      check(res_dw1 == exp_dw1, "R7 second doubleword", res_dw1, exp_dw1);
    end else if (!exp_err) begin
      check(res_slot == 3'd0, "R8 miss slot index", 64'(res_slot), 64'd0);
    end
    check(order_err == oe0, "R7 ascending read order", 64'(order_err - oe0), 64'd0);
    if (exp_err) check(rd_cnt == 0, "R9 no memory reads", 64'(rd_cnt), 64'd0);
    if (hold > 0) begin
      h0 = res_hit; e0 = res_err; s0 = res_slot; d0 = res_dw1;
      stable_ok = 1'b1;
      req_valid = 1'b1;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        if (!res_valid || res_hit != h0 || res_err != e0 || res_slot != s0 || res_dw1 != d0 || req_ready)
          stable_ok = 1'b0;
      end
      req_valid = 1'b0;
      check(stable_ok, "R10 result held, request blocked", 64'(stable_ok), 64'd1);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    if (hold > 0)
      check(!res_valid && req_ready, "R10 released after accept", {62'd0, res_valid, req_ready}, 64'd1);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t;
    logic [63:0] vpn, cmp;
    int p, g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !res_valid && !rd_en, "R11 reset state",
          {61'd0, req_ready, res_valid, rd_en}, 64'd4);
    t = 0;
    for (int base = 0; base < 4; base++)
      for (int act = 0; act < 4; act++)
        for (int ssz = 0; ssz < 2; ssz++)
          for (int lay = 0; lay < 2; lay++)
            for (int sec = 0; sec < 2; sec++) begin
              vpn = ((64'h9E37_79B9_7F4A_7C15 * 64'(t + 1)) ^ (64'(t) << 20)) & 64'h00FF_FFFF_FFFF_FFFF;
              cmp = ref_cmp(vpn, base, ssz);
              p = t % 9;
              g = t % 4;
              fill_group(g, p, t, cmp, sec[0], act != 0, 2'(ssz), lay[0]);
              run_search(vpn, base, act, ssz, sec[0], lay[0], g, p < 8, 1'b0, p,
                         (p < 8) ? m1[g * 8 + p] : 64'd0, (t % 37 == 5) ? 4 : 0);
              t++;
            end
    // reserved segment sizes end with an error and no reads
    for (int rs = 2; rs < 4; rs++) begin
      vpn = 64'h0000_1234_5678_9ABC;
      fill_group(1, 3, 7, ref_cmp(vpn, 0, rs), 1'b0, 1'b0, 2'(rs), 1'b0);
      run_search(vpn, 0, 0, rs, 1'b0, 1'b0, 1, 1'b0, 1'b1, 0, 64'd0, 3);
    end
    // true entry only in the last slot
    vpn = 64'h0012_3456_789A_BCDE;
    fill_group(2, 7, 3, ref_cmp(vpn, 3, 1), 1'b1, 1'b1, 2'd1, 1'b1);
    run_search(vpn, 3, 2, 1, 1'b1, 1'b1, 2, 1'b1, 1'b0, 7, m1[2 * 8 + 7], 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule